// File: doc/BRIEF.md
# Partitioned Binary Radix Sorter

This block sorts a fixed-size set of unsigned keys held in two on-chip key buffers. Keys are written one at a time through a load port while the block is idle. A start pulse launches the sort, and the result is then read back through a registered readout port.

The sort makes one pass for each key bit, starting with the least significant bit. Each pass is split across a set of equal partitions, and every partition has its own worker. A pass runs in three phases:

- Each worker scans its partition and counts the keys whose current bit is zero.
- A prefix-sum stage turns those counts into a base address for each worker's zero group and one for its one group.
- All workers copy their keys into the other buffer at the same time, each advancing its own two write pointers.

After every pass the two buffers swap roles. The result always sits in the buffer written last, and that buffer is also the one that loads fill and the next sort reads from.

Top module: `radix_sort_engine`

## Requirements
- R1: A load (`ld_en` high) while `busy` is low stores `ld_key` at `ld_addr` in the current result buffer, and a later read of that address returns it.
- R2: After reset `busy`, `done` and `rd_key` are 0. A `start` sampled while idle raises `busy` and clears `done` at that same edge. `busy` and `done` are never high together, and `done` stays high until the next accepted `start`.
- R3: A sort makes exactly KEY_W passes. `busy` stays high for exactly KEY_W*(2*PART_SIZE+1) cycles, and `done` rises at the edge where the last pass completes.
- R4: After a sort, address 0 upward holds the keys in ascending order, and keys that are equal in a pass keep their relative order. For example, 9,6,1,2,11,4,8,13 becomes 1,2,4,6,8,9,11,13.
- R5: A worker's zero count never exceeds PART_SIZE.
- R6: A `start` pulse while `busy` is high is ignored: the running sort keeps its original completion cycle.
- R7: A load while `busy` is high is ignored and does not change the sorted result.
- R8: `rd_key` is registered: it shows the result-buffer entry at the `rd_addr` sampled on the previous clock edge.
- R9: Degenerate inputs sort correctly: all keys equal, all keys zero, all keys at the maximum, reversed order, and many duplicates.
- R10: During the scatter phase, all workers write to distinct buffer addresses in every cycle.
- R11: Partition 0 writes its zero keys from address 0, the last partition's one region ends exactly at N, and no scatter address reaches N.
- R12: A new `start` sorts the current result buffer in place, so sorting an already sorted set leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one key into the result buffer (idle only) |
| ld_addr | input | AW | Load address |
| ld_key | input | KEY_W | Key to load |
| start | input | 1 | Begin a sort (idle only) |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Last sort finished; held until next start |
| rd_addr | input | AW | Readout address |
| rd_key | output | KEY_W | Registered readout of the result buffer |

## Verification
Several properties are checked on every clock:

- scatter addresses never collide and never reach N;
- the prefix-sum bases tile the output exactly;
- zero counts stay within a partition's size;
- `busy` and `done` are exclusive;
- `done` only rises after the last-bit pass.

Ordering and stability of the final result, the exact busy length, and the way starts and loads are ignored during a sort can only be shown by the bench scenarios. These are checked against a behavioural model cycle by cycle, and through readout after each sort.

// File: rtl/rsort_pkg.sv
package rsort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COUNT   = 2'd1,
    ST_OFFSET  = 2'd2,
    ST_SCATTER = 2'd3
  } rsort_state_t;

endpackage

// File: rtl/rsort_worker.sv
module rsort_worker #(
  parameter int PART_SIZE = 2,
  parameter int N         = 8,
  parameter int CW        = 2,
  parameter int BW        = 4,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_clr,
  input  logic          cnt_en,
  input  logic          ptr_load,
  input  logic          step_en,
  input  logic          key_bit,
  input  logic [BW-1:0] zero_base,
  input  logic [BW-1:0] one_base,
  output logic [CW-1:0] zero_cnt,
  output logic [AW-1:0] wr_addr
);

  logic [BW-1:0] zptr;
  logic [BW-1:0] optr;

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      zero_cnt <= '0;
    end else if (cnt_en && !key_bit) begin
      zero_cnt <= zero_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zptr <= '0;
      optr <= '0;
    end else if (ptr_load) begin
      zptr <= zero_base;
      optr <= one_base;
    end else if (step_en) begin
      if (key_bit) optr <= optr + BW'(1);
      else         zptr <= zptr + BW'(1);
    end
  end

  assign wr_addr = key_bit ? optr[AW-1:0] : zptr[AW-1:0];

  // R5
  zero_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    zero_cnt <= CW'(PART_SIZE));

  // R11
  scatter_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |-> ((key_bit ? optr : zptr) < BW'(N)));

endmodule

// File: rtl/rsort_offsets.sv
module rsort_offsets #(
  parameter int PARTS     = 4,
  parameter int PART_SIZE = 2,
  parameter int CW        = 2,
  parameter int BW        = 4
) (
  input  logic [PARTS-1:0][CW-1:0] zeros,
  output logic [PARTS-1:0][BW-1:0] zero_base,
  output logic [PARTS-1:0][BW-1:0] one_base
);

  logic [BW-1:0] total_zeros;
  logic [BW-1:0] zacc;
  logic [BW-1:0] oacc;

  always_comb begin
    total_zeros = '0;
    for (int j = 0; j < PARTS; j++) begin
      total_zeros = total_zeros + BW'(zeros[j]);
    end
    zacc = '0;
    oacc = total_zeros;
    for (int j = 0; j < PARTS; j++) begin
      zero_base[j] = zacc;
      one_base[j]  = oacc;
      zacc = zacc + BW'(zeros[j]);
      oacc = oacc + BW'(PART_SIZE) - BW'(zeros[j]);
    end
  end

endmodule

// File: rtl/radix_sort_engine.sv
module radix_sort_engine
  import rsort_pkg::*;
#(
  parameter int KEY_W     = 4,
  parameter int PARTS     = 4,
  parameter int PART_SIZE = 2,
  localparam int N        = PARTS * PART_SIZE,
  localparam int AW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [KEY_W-1:0] ld_key,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [AW-1:0]    rd_addr,
  output logic [KEY_W-1:0] rd_key
);

  localparam int BW = $clog2(N + 1);
  localparam int CW = $clog2(PART_SIZE + 1);
  localparam int IW = (PART_SIZE > 1) ? $clog2(PART_SIZE) : 1;
  localparam int PW = (KEY_W > 1) ? $clog2(KEY_W) : 1;

  logic [KEY_W-1:0] buf0 [N];
  logic [KEY_W-1:0] buf1 [N];

  rsort_state_t     state;
  logic [PW-1:0]    pass;
  logic [IW-1:0]    idx;
  logic             sel;
  logic             last_idx;
  logic             last_pass;

  logic [PARTS-1:0][CW-1:0] zcnt;
  logic [PARTS-1:0][BW-1:0] zbase;
  logic [PARTS-1:0][BW-1:0] obase;
  logic [PARTS-1:0]         kbit;
  logic [AW-1:0]            waddr [PARTS];
  logic [KEY_W-1:0]         skey  [PARTS];

  logic cnt_clr, cnt_en, ptr_load, step_en;

  assign last_idx  = (idx == IW'(PART_SIZE - 1));
  assign last_pass = (pass == PW'(KEY_W - 1));
  assign cnt_clr   = (state == ST_IDLE) || (state == ST_SCATTER);
  assign cnt_en    = (state == ST_COUNT);
  assign ptr_load  = (state == ST_OFFSET);
  assign step_en   = (state == ST_SCATTER);

  // Sequencer: COUNT (PART_SIZE cycles), OFFSET (1), SCATTER (PART_SIZE)
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pass  <= '0;
      idx   <= '0;
      sel   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_COUNT;
            pass  <= '0;
            idx   <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
          end
        end
        ST_COUNT: begin
          if (last_idx) begin
            idx   <= '0;
            state <= ST_OFFSET;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_OFFSET: begin
          state <= ST_SCATTER;
        end
        ST_SCATTER: begin
          if (last_idx) begin
            idx <= '0;
            sel <= ~sel;
            if (last_pass) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              pass  <= pass + PW'(1);
              state <= ST_COUNT;
            end
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // One worker per partition, each reading its own slice of the source buffer
  for (genvar g = 0; g < PARTS; g++) begin : g_part
    logic [AW-1:0] src_addr;
    assign src_addr = AW'(g * PART_SIZE) + AW'(idx);
    assign skey[g]  = sel ? buf1[src_addr] : buf0[src_addr];
    assign kbit[g]  = skey[g][pass];

    rsort_worker #(
      .PART_SIZE (PART_SIZE),
      .N         (N),
      .CW        (CW),
      .BW        (BW),
      .AW        (AW)
    ) i_worker (
      .clk       (clk),
      .rst       (rst),
      .cnt_clr   (cnt_clr),
      .cnt_en    (cnt_en),
      .ptr_load  (ptr_load),
      .step_en   (step_en),
      .key_bit   (kbit[g]),
      .zero_base (zbase[g]),
      .one_base  (obase[g]),
      .zero_cnt  (zcnt[g]),
      .wr_addr   (waddr[g])
    );
  end

  rsort_offsets #(
    .PARTS     (PARTS),
    .PART_SIZE (PART_SIZE),
    .CW        (CW),
    .BW        (BW)
  ) i_offsets (
    .zeros     (zcnt),
    .zero_base (zbase),
    .one_base  (obase)
  );

  // Key buffers: loads go to the result buffer, scatter goes to the other
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && ld_en) begin
      if (sel) buf1[ld_addr] <= ld_key;
      else     buf0[ld_addr] <= ld_key;
    end
    if (state == ST_SCATTER) begin
      for (int j = 0; j < PARTS; j++) begin
        if (sel) buf0[waddr[j]] <= skey[j];
        else     buf1[waddr[j]] <= skey[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_key <= '0;
    else     rd_key <= sel ? buf1[rd_addr] : buf0[rd_addr];
  end

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R3
  done_after_last_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state) == ST_SCATTER && $past(pass) == PW'(KEY_W - 1)));

  // R2
  busy_tracks_state_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> busy);

  // R11
  bases_tile_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFSET) |->
      (zbase[0] == '0 &&
       (32'(obase[PARTS-1]) + PART_SIZE - 32'(zcnt[PARTS-1])) == N));

  // R10
  always @(posedge clk) begin
    if (!rst && state == ST_SCATTER) begin
      for (int a = 0; a < PARTS; a++) begin
        for (int b = a + 1; b < PARTS; b++) begin
          scatter_distinct_chk: assert (waddr[a] != waddr[b]);
        end
      end
    end
  end

endmodule

// File: tb/test_radix_sort_engine.sv
module test_radix_sort_engine;

  localparam int KEY_W     = 4;
  localparam int PARTS     = 4;
  localparam int PART_SIZE = 2;
  localparam int N         = PARTS * PART_SIZE;
  localparam int AW        = $clog2(N);
  localparam int LAT       = KEY_W * (2 * PART_SIZE + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ld_en = 1'b0;
  logic [AW-1:0]    ld_addr = '0;
  logic [KEY_W-1:0] ld_key = '0;
  logic             start = 1'b0;
  logic             busy;
  logic             done;
  logic [AW-1:0]    rd_addr = '0;
  logic [KEY_W-1:0] rd_key;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  radix_sort_engine #(
    .KEY_W     (KEY_W),
    .PARTS     (PARTS),
    .PART_SIZE (PART_SIZE)
  ) i_radix_sort_engine (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_key  (ld_key),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_addr (rd_addr),
    .rd_key  (rd_key)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Behavioural reference: buffer contents and handshake timing
  int ref_mem [N];
  bit m_busy = 0;
  bit m_done = 0;
  int m_cnt  = 0;
  bit mon_on = 0;

  task automatic ref_sort();
    for (int i = 1; i < N; i++) begin
      int v = ref_mem[i];
      int k = i - 1;
      while (k >= 0 && ref_mem[k] > v) begin
        ref_mem[k + 1] = ref_mem[k];
        k--;
      end
      ref_mem[k + 1] = v;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        m_busy = 0; m_done = 1;
        ref_sort();
      end
      m_cnt--;
    end else begin
      if (ld_en) ref_mem[ld_addr] = int'(ld_key);
      if (start) begin
        m_busy = 1; m_done = 0; m_cnt = LAT;
      end
    end
  end

  // R2 R3 R6: handshake compared with the model on every cycle
  always @(negedge clk) begin
    if (mon_on) begin
      chk(busy == m_busy, "R2 R3 R6 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R2 R3 done", int'(done), int'(m_done));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic load(input int a, input int k);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_addr = AW'(a); ld_key = KEY_W'(k);
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic load_set(input int k [N]);
    for (int i = 0; i < N; i++) load(i, k[i]);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4 * LAT; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic run_sort();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(posedge clk); #1 rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    chk(int'(rd_key) == exp, req, int'(rd_key), exp);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) rd_chk(i, ref_mem[i], req);
  endtask

  initial begin
    int ex_in  [N] = '{9, 6, 1, 2, 11, 4, 8, 13};
    int ex_out [N] = '{1, 2, 4, 6, 8, 9, 11, 13};
    int rev    [N] = '{15, 14, 13, 12, 11, 10, 9, 8};
    int same   [N] = '{7, 7, 7, 7, 7, 7, 7, 7};
    int zer    [N] = '{0, 0, 0, 0, 0, 0, 0, 0};
    int mx     [N] = '{15, 15, 15, 15, 15, 15, 15, 15};
    int dup    [N] = '{3, 0, 3, 15, 0, 15, 3, 0};

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R2 reset done", int'(done), 0);
    chk(rd_key == '0, "R2 reset rd_key", int'(rd_key), 0);
    mon_on = 1;

    // R1 R8: loaded keys read back before any sort
    load_set(ex_in);
    check_all("R1 R8 readback");

    // R3 R4 R5 R10 R11: example from the requirement list
    run_sort();
    for (int i = 0; i < N; i++) rd_chk(i, ex_out[i], "R4 R5 R10 R11 example");

    // R12: sorting the result again leaves it unchanged
    run_sort();
    for (int i = 0; i < N; i++) rd_chk(i, ex_out[i], "R12 resort");

    // R9 boundaries
    load_set(rev);  run_sort(); check_all("R9 reversed");
    load_set(same); run_sort(); check_all("R9 all equal");
    load_set(zer);  run_sort(); check_all("R9 all zero");
    load_set(mx);   run_sort(); check_all("R9 all max");
    load_set(dup);  run_sort(); check_all("R9 duplicates");

    // R6 R7: start and load during a sort are ignored
    load_set(rev);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (5) @(posedge clk);
    #1 start = 1'b1; ld_en = 1'b1; ld_addr = '0; ld_key = '0;
    @(posedge clk); #1 start = 1'b0; ld_en = 1'b0;
    wait_done();
    rd_chk(0, 8, "R7 load ignored");
    check_all("R6 R7 result");

    mon_on = 0;
    finish_run();
  end

endmodule